// File: doc/BRIEF.md
# Reload-On-Write Watchdog Timer

This block is a down-counting watchdog that runs at the input clock and has a single write port. After power-on it sits idle. The first write of a non-zero value arms it and latches that value as the timeout, measured in clock cycles. Every later write restarts the count from the latched value, whatever data it carries. Software keeps the system alive by writing before the count runs out.

If the count runs out, the block raises a one-cycle system reset request. It then returns to the idle state with the latched timeout cleared, as the reset it requests would leave it. A sticky flag records that the watchdog caused the reset. The watchdog's own request does not clear this flag. Only power-on reset or a write of zero clears it. A zero write never arms an idle watchdog, so software can clear the flag at boot without starting the timer.

Top module: `wdog_reload`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `armed`=0, `count`=0, `wdt_flag`=0 and `sys_rst_req`=0.
- R2: A write of non-zero data while idle sets `armed` to 1 and loads `count` with the written data on the following cycle.
- R3: While armed with no write, `count` drops by exactly one per clock cycle.
- R4: A write while armed reloads `count` with the value latched at the first write, and its own data has no effect on the count.
- R5: After a load or reload to value N with no further writes, `sys_rst_req` is high for exactly one cycle, N cycles after the load cycle. In that cycle `count` reads 0.
- R6: When the count expires, `wdt_flag` becomes 1 and `armed` becomes 0. While idle, `count` stays at 0.
- R7: `wdt_flag` stays set through the watchdog's own reset request and any non-zero writes. Only `rst` or a zero write clears it.
- R8: A write of zero while idle clears `wdt_flag` and leaves `armed` at 0.
- R9: A write of zero while armed clears `wdt_flag` and reloads `count` from the latched timeout.
- R10: A write in the cycle whose edge would otherwise expire the count reloads the count, and no reset request is raised.
- R11: After an expiry, the next non-zero write acts as a first write and latches a new timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock. The count runs on this clock. |
| rst | input | 1 | Synchronous active-high power-on reset. |
| wr_en | input | 1 | Write strobe for the timeout register. |
| wr_data | input | CNT_W | Data for the write. Used only on the first write. |
| sys_rst_req | output | 1 | One-cycle system reset request on expiry. |
| wdt_flag | output | 1 | Sticky flag showing that a watchdog timeout occurred. |
| armed | output | 1 | High while the watchdog is running. |
| count | output | CNT_W | Cycles remaining before expiry. |

## Verification
The bench builds the block with the default 16-bit width. Short timeouts of 1, 3 and 5 cycles put expiry, a reload on the last edge, and re-arming after expiry within a few cycles of each other. A timeout of 0xFFFF drives the counter through its full range to the top value. A reference model kept with plain integers is compared against every output on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned WD_W_DEF = 16;

    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_RUN  = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic arm_first;   // first non-zero write while idle
        logic reload;      // any write while running
        logic clr_flag;    // zero-valued write
        logic ignored;     // zero write while idle: no arming
    } wd_cmd_t;

    function automatic wd_cmd_t wd_decode(input logic wr,
                                          input logic data_zero,
                                          input wd_state_e st);
        wd_cmd_t c;
        c.arm_first = wr && (st == WD_IDLE) && !data_zero;
        c.reload    = wr && (st == WD_RUN);
        c.clr_flag  = wr && data_zero;
        c.ignored   = wr && (st == WD_IDLE) && data_zero;
        return c;
    endfunction

endpackage

// File: rtl/wdog_cmd_dec.sv
module wdog_cmd_dec
    import wdog_pkg::*;
#(
    parameter int unsigned W = WD_W_DEF
) (
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  wd_state_e        st,
    output wd_cmd_t          cmd
);
    logic data_zero;

    always_comb begin
        data_zero = (wr_data == '0);
        cmd       = wd_decode(wr_en, data_zero, st);
    end

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int unsigned W = WD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  wd_cmd_t      cmd,
    input  logic [W-1:0] wr_data,
    input  logic         expire,
    output wd_state_e    st,
    output logic [W-1:0] tmo
);
    wd_state_e    st_q;
    logic [W-1:0] tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WD_IDLE;
            tmo_q <= '0;
        end else if (expire) begin
            st_q  <= WD_IDLE;
            tmo_q <= '0;
        end else if (cmd.arm_first) begin
            st_q  <= WD_RUN;
            tmo_q <= wr_data;
        end
    end

    assign st  = st_q;
    assign tmo = tmo_q;

    // R8: a zero write never arms an idle watchdog
    p_zero_noarm_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == WD_IDLE && cmd.ignored) |=> (st_q == WD_IDLE));

    // R4: latched timeout is untouched by later writes while running
    p_tmo_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == WD_RUN && !expire) |=> $stable(tmo_q));

    // R11: after expiry the latched value is cleared
    p_tmo_clear_r11: assert property (@(posedge clk) disable iff (rst)
        expire |=> (tmo_q == '0 && st_q == WD_IDLE));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned W = WD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  wd_state_e    st,
    input  wd_cmd_t      cmd,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] tmo,
    output logic [W-1:0] cnt,
    output logic         expire,
    output logic         req
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic         req_q;

    always_comb begin
        expire = (st == WD_RUN) && !cmd.reload && (cnt_q == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= expire;
            if (cmd.arm_first)
                cnt_q <= wr_data;
            else if (cmd.reload)
                cnt_q <= tmo;
            else if (expire)
                cnt_q <= '0;
            else if (st == WD_RUN)
                cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt = cnt_q;
    assign req = req_q;

    // R3: one step down per cycle while running without a write
    p_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (st == WD_RUN && !cmd.reload && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

    // R5: request is a single-cycle pulse
    p_pulse_one_r5: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R6: idle count holds at zero
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st == WD_IDLE && !cmd.arm_first && cnt_q == '0) |=> (cnt_q == '0));

    // R10: a write on the last edge prevents the request
    p_late_write_r10: assert property (@(posedge clk) disable iff (rst)
        (st == WD_RUN && cmd.reload) |=> !req_q);

endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wd_cmd_t cmd,
    input  logic    expire,
    output logic    flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (expire)
            flag_q <= 1'b1;
        else if (cmd.clr_flag)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R6: expiry sets the flag
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    // R7: only a zero write (or power-on reset) clears the flag
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !cmd.clr_flag) |=> flag_q);

    // R8/R9: zero write without expiry clears it
    p_flag_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_flag && !expire) |=> !flag_q);

endmodule

// File: rtl/wdog_reload.sv
module wdog_reload
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = WD_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic             sys_rst_req,
    output logic             wdt_flag,
    output logic             armed,
    output logic [CNT_W-1:0] count
);
    wd_cmd_t          cmd;
    wd_state_e        st;
    logic [CNT_W-1:0] tmo;
    logic             expire;

    wdog_cmd_dec #(.W(CNT_W)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .st      (st),
        .cmd     (cmd)
    );

    wdog_cfg #(.W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wr_data (wr_data),
        .expire  (expire),
        .st      (st),
        .tmo     (tmo)
    );

    wdog_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .st      (st),
        .cmd     (cmd),
        .wr_data (wr_data),
        .tmo     (tmo),
        .cnt     (count),
        .expire  (expire),
        .req     (sys_rst_req)
    );

    wdog_status u_sts (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .expire (expire),
        .flag   (wdt_flag)
    );

    assign armed = (st == WD_RUN);

    // R4: any write while armed restores the latched timeout
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && wr_en) |=> (count == $past(tmo)));

    // R2: first non-zero write arms and loads its data
    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (!armed && wr_en && wr_data != '0) |=> (armed && count == $past(wr_data)));

    // R5: request coincides with a zero count and a disarmed state
    p_req_state_r5: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> (count == '0 && !armed && wdt_flag));

endmodule

// File: tb/tb_wdog_reload.sv
module tb_wdog_reload;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         sys_rst_req, wdt_flag, armed;
    logic [W-1:0] count;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int m_armed = 0, m_tmo = 0, m_cnt = 0, m_flag = 0, m_req = 0;

    wdog_reload #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .sys_rst_req(sys_rst_req), .wdt_flag(wdt_flag),
        .armed(armed), .count(count)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        m_req = 0;
        if (rst) begin
            m_armed = 0; m_tmo = 0; m_cnt = 0; m_flag = 0;
        end else begin
            if (wr_en && wr_data == 0) m_flag = 0;
            if (m_armed == 0) begin
                if (wr_en && wr_data != 0) begin
                    m_armed = 1; m_tmo = int'(wr_data); m_cnt = int'(wr_data);
                end
            end else if (wr_en) begin
                m_cnt = m_tmo;
            end else if (m_cnt == 1) begin
                m_req = 1; m_armed = 0; m_tmo = 0; m_cnt = 0; m_flag = 1;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            chk("R3 model count", int'(count), m_cnt);
            chk("R5 model request", int'(sys_rst_req), m_req);
            chk("R7 model flag", int'(wdt_flag), m_flag);
            chk("R6 model armed", int'(armed), m_armed);
        end
    end

    // drive at a falling edge, return at the next falling edge
    task automatic step(input bit w, input logic [W-1:0] d);
        wr_en = w;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0);
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        chk("R1 armed", int'(armed), 0);
        chk("R1 count", int'(count), 0);
        chk("R1 flag", int'(wdt_flag), 0);
        chk("R1 request", int'(sys_rst_req), 0);

        step(1'b1, 16'd0);
        chk("R8 zero write idle stays disarmed", int'(armed), 0);

        step(1'b1, 16'd5);
        chk("R2 armed", int'(armed), 1);
        chk("R2 count loaded", int'(count), 5);
        idle(2);
        chk("R3 count after two cycles", int'(count), 3);
        step(1'b1, 16'h1234);
        chk("R4 reload ignores data", int'(count), 5);
        idle(4);
        chk("R5 no request yet", int'(sys_rst_req), 0);
        idle(1);
        chk("R5 request after 5 cycles", int'(sys_rst_req), 1);
        chk("R5 count zero at request", int'(count), 0);
        chk("R6 flag set", int'(wdt_flag), 1);
        chk("R6 disarmed", int'(armed), 0);
        idle(1);
        chk("R5 request one cycle", int'(sys_rst_req), 0);
        idle(10);
        chk("R6 idle count held", int'(count), 0);
        chk("R7 flag held", int'(wdt_flag), 1);

        step(1'b1, 16'd3);
        chk("R11 new timeout latched", int'(count), 3);
        chk("R7 flag kept on nonzero write", int'(wdt_flag), 1);
        idle(2);
        chk("R10 count at last step", int'(count), 1);
        step(1'b1, 16'd99);
        chk("R10 reloaded on last edge", int'(count), 3);
        chk("R10 no request", int'(sys_rst_req), 0);
        step(1'b1, 16'd0);
        chk("R9 zero write reloads", int'(count), 3);
        chk("R9 zero write clears flag", int'(wdt_flag), 0);
        chk("R9 still armed", int'(armed), 1);
        idle(3);
        chk("R5 request after reload", int'(sys_rst_req), 1);
        chk("R6 flag set again", int'(wdt_flag), 1);

        step(1'b1, 16'd0);
        chk("R8 zero write clears flag idle", int'(wdt_flag), 0);
        chk("R8 not armed", int'(armed), 0);

        step(1'b1, 16'd2);
        idle(2);
        chk("R6 flag before power-on reset", int'(wdt_flag), 1);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        chk("R7 power-on reset clears flag", int'(wdt_flag), 0);

        step(1'b1, 16'd1);
        chk("R2 one-cycle timeout loaded", int'(count), 1);
        idle(1);
        chk("R5 one-cycle timeout request", int'(sys_rst_req), 1);

        step(1'b1, 16'hFFFF);
        chk("R2 full-range load", int'(count), 65535);
        idle(65534);
        chk("R3 full-range count", int'(count), 1);
        chk("R5 no early request", int'(sys_rst_req), 0);
        idle(1);
        chk("R5 full-range request", int'(sys_rst_req), 1);
        idle(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_800_000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule